// File: doc/BRIEF.md
# Rename Undo Log

This block keeps an ordered record of every speculative register mapping made by the rename stage. The record lets the pipeline undo those mappings when it throws away wrong-path work, and retire them when older work completes. Each accepted allocation writes one record at the young end of a circular log. A record holds the instruction sequence number, the architectural register, the physical register just handed out, and the physical register it displaced. The same cycle, the block tells the scoreboard to mark the new physical register not ready.

Three kinds of walk remove records, one record per clock:

- **Squash walk.** It starts from the young end. For each record it puts the displaced mapping back into the map table and returns the new physical register to the free list.
- **Retire walk.** It starts from the old end. For each record it returns the displaced physical register to the free list.
- **Flush walk.** It empties the log from the young end, whatever the sequence numbers are. It is used when the pipeline is handed over.

During any rollback, a physical register at or above the count of ordinary integer and floating-point registers is forced ready in the scoreboard. Two event counters report how many records were retired and how many were undone.

Top module: `rename_undo_log`

## Requirements
- R1: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is high only when the log is not full and no walk is in progress. The record is added at the young end, and `occupancy` rises by one at the next clock. In the acceptance cycle, `sb_clr_we` is high and `sb_clr_phys` equals `alloc_new`.
- R2: When `occupancy` equals DEPTH, `full` is high and `alloc_ready` is low. A request made then changes nothing: `occupancy` stays at DEPTH.
- R3: A squash (`squash_valid` with number S) starts a walk that emits from the cycle after the request.
  - Each cycle it takes the youngest record while that record's sequence number is greater than S (unsigned compare, no wraparound).
  - For that record it drives `map_we` with `map_arch`/`map_phys` equal to the architectural and displaced registers, and `free_we` with `free_phys` equal to the new register, then removes the record.
  - The walk stops at the first record with number ≤ S, or when the log is empty.
  - `busy` is high from the cycle after the request through the cycle in which the stop condition is found.
- R4: While rolling back a record whose new physical register is ≥ REGULAR_REGS, `sb_set_we` is high with `sb_set_phys` equal to that register. Below that bound, `sb_set_we` stays low.
- R5: When idle, a non-zero `commit_seq` D starts a retire walk.
  - Each cycle it takes the oldest record while that record's number is ≤ D, drives `free_we` with the displaced register (and `map_we` low), and removes the record.
  - If the log is empty, or the oldest record is already newer than D, nothing is released.
- R6: `commit_seq` is ignored when it is zero, when `squash_valid` or `flush_all` is high in the same cycle, and whenever a walk is already in progress.
- R7: `flush_all` rolls back every record, youngest first, with the same outputs as R3 and R4. It takes priority over a squash or commit in the same cycle, and squash requests during a flush are ignored.
- R8: A squash arriving during a retire walk ends that walk and starts a squash walk. A squash arriving during a squash walk continues with the smaller of the two numbers. `flush_all` during any other walk switches to a flush walk. In every case, the record handled in the arrival cycle is still handled under the walk in progress.
- R9: `commits_done` increases by one for each retired record. `undos_done` increases by one for each record rolled back by a squash or flush walk.
- R10: After a synchronous active-low reset:
  - the log is empty and `busy` is low;
  - `alloc_ready` is high;
  - all strobes are low;
  - both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Rename offers a new mapping record |
| alloc_seq | input | SEQ_W | Sequence number of the renaming instruction |
| alloc_arch | input | ARCH_W | Architectural destination register |
| alloc_new | input | PHYS_W | Newly assigned physical register |
| alloc_prev | input | PHYS_W | Physical register previously mapped |
| alloc_ready | output | 1 | Log can take a record this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| flush_all | input | 1 | Roll back every record |
| commit_seq | input | SEQ_W | Completed sequence number, zero for none |
| map_we | output | 1 | Map table restore strobe |
| map_arch | output | ARCH_W | Architectural register to restore |
| map_phys | output | PHYS_W | Physical register to restore into the map |
| free_we | output | 1 | Free list return strobe |
| free_phys | output | PHYS_W | Physical register returned |
| sb_set_we | output | 1 | Scoreboard force-ready strobe |
| sb_set_phys | output | PHYS_W | Register forced ready |
| sb_clr_we | output | 1 | Scoreboard clear-ready strobe |
| sb_clr_phys | output | PHYS_W | Register marked not ready |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | Log holds DEPTH records |
| occupancy | output | CNT_W | Number of records held |
| commits_done | output | EV_W | Retired record count |
| undos_done | output | EV_W | Rolled-back record count |

## Verification
The scoreboard strobe on allocation is combinational and is due in the acceptance cycle itself. `occupancy` moves at the following edge. Walk strobes appear one cycle after the request, because the request is registered first. After that there is one record per cycle, and `busy` drops one cycle after the last record leaves.

The bench drives inputs on the falling edge and compares every output a little later, against a behavioural queue model. It advances that model only at the rising edge, so each expected value stands for exactly the cycle being sampled.

// File: rtl/rul_pkg.sv
// Shared types for the rename undo log.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rul_pkg;
    // Walk currently in progress.
    typedef enum logic [1:0] {
        WALK_NONE   = 2'd0,
        WALK_SQUASH = 2'd1,
        WALK_RETIRE = 2'd2,
        WALK_FLUSH  = 2'd3
    } walk_e;
endpackage

// File: rtl/rul_store.sv
// Circular record store: push at the young end, pop at either end.
// Assumes push never coincides with a pop and never happens when full;
// the controller guarantees both.
module rul_store #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int ARCH_W = 5,
    parameter int PHYS_W = 7,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [ARCH_W-1:0] push_arch,
    input  logic [PHYS_W-1:0] push_new,
    input  logic [PHYS_W-1:0] push_prev,
    input  logic              pop_young,
    input  logic              pop_old,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              is_full,
    output logic [SEQ_W-1:0]  yng_seq,
    output logic [ARCH_W-1:0] yng_arch,
    output logic [PHYS_W-1:0] yng_new,
    output logic [PHYS_W-1:0] yng_prev,
    output logic [SEQ_W-1:0]  old_seq,
    output logic [PHYS_W-1:0] old_prev
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [SEQ_W-1:0]  seq_m  [DEPTH];
    logic [ARCH_W-1:0] arch_m [DEPTH];
    logic [PHYS_W-1:0] new_m  [DEPTH];
    logic [PHYS_W-1:0] prev_m [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q, yng_idx;
    logic [CNT_W-1:0]  cnt_q;

    // Per-slot write of a new record.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_q == PTR_W'(g)) begin
                seq_m[g]  <= push_seq;
                arch_m[g] <= push_arch;
                new_m[g]  <= push_new;
                prev_m[g] <= push_prev;
            end
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q  <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
            end else if (pop_young) begin
                wr_q  <= yng_idx;
                cnt_q <= cnt_q - 1'b1;
            end else if (pop_old) begin
                rd_q  <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Index of the youngest record and read-out of both ends.
    always_comb begin
        yng_idx  = (wr_q == '0) ? LAST : wr_q - 1'b1;
        yng_seq  = seq_m[yng_idx];
        yng_arch = arch_m[yng_idx];
        yng_new  = new_m[yng_idx];
        yng_prev = prev_m[yng_idx];
        old_seq  = seq_m[rd_q];
        old_prev = prev_m[rd_q];
    end

    assign count   = cnt_q;
    assign empty   = (cnt_q == '0);
    assign is_full = (cnt_q == CNT_W'(DEPTH));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !is_full);
    // R1
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !(pop_young || pop_old));
    // R9
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_young || pop_old) && !empty |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rul_walker.sv
// Walk controller: accepts squash, flush and retire requests and removes
// one record per cycle from the proper end of the store.
// Assumes sequence numbers grow monotonically without wraparound.
module rul_walker
    import rul_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             empty,
    input  logic [SEQ_W-1:0] yng_seq,
    input  logic [SEQ_W-1:0] old_seq,
    output logic             pop_young,
    output logic             pop_old,
    output logic             walking
);
    walk_e            st_q, st_d;
    logic [SEQ_W-1:0] tgt_q, tgt_d;

    // Action for the current walk, then overlay of new requests.
    always_comb begin
        pop_young = 1'b0;
        pop_old   = 1'b0;
        st_d      = st_q;
        tgt_d     = tgt_q;
        unique case (st_q)
            WALK_NONE:   ;
            WALK_SQUASH: if (!empty && yng_seq > tgt_q) pop_young = 1'b1;
                         else st_d = WALK_NONE;
            WALK_RETIRE: if (!empty && old_seq <= tgt_q) pop_old = 1'b1;
                         else st_d = WALK_NONE;
            WALK_FLUSH:  if (!empty) pop_young = 1'b1;
                         else st_d = WALK_NONE;
        endcase
        if (st_q != WALK_FLUSH) begin
            if (flush_all) begin
                st_d = WALK_FLUSH;
            end else if (squash_valid) begin
                st_d  = WALK_SQUASH;
                tgt_d = (st_q == WALK_SQUASH && tgt_q < squash_seq) ? tgt_q : squash_seq;
            end else if (st_q == WALK_NONE && commit_seq != '0) begin
                st_d  = WALK_RETIRE;
                tgt_d = commit_seq;
            end
        end
    end

    // Walk state and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WALK_NONE;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    assign walking = (st_q != WALK_NONE);

    // R3
    squash_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WALK_NONE && squash_valid && !flush_all) |=> st_q == WALK_SQUASH);
    // R6
    retire_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WALK_SQUASH && !flush_all && !squash_valid) |=> st_q != WALK_RETIRE);
    // R7
    flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WALK_FLUSH && !empty) |=> st_q == WALK_FLUSH);
    // R5
    one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pop_young, pop_old}));
endmodule

// File: rtl/rul_event_ctr.sv
// Free-running event counter with synchronous clear; wraps at its width.
module rul_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count one per qualifying cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/rename_undo_log.sv
// Rename undo log top: records speculative mappings and walks them back
// on squash or flush, or releases displaced registers on retire.
// Assumes the map table, free list and scoreboard accept one write per
// cycle on each port and that sequence numbers never wrap.
module rename_undo_log #(
    parameter int DEPTH        = 8,
    parameter int SEQ_W        = 16,
    parameter int ARCH_W       = 5,
    parameter int PHYS_W       = 7,
    parameter int REGULAR_REGS = 96,
    parameter int EV_W         = 16,
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ARCH_W-1:0] alloc_arch,
    input  logic [PHYS_W-1:0] alloc_new,
    input  logic [PHYS_W-1:0] alloc_prev,
    output logic              alloc_ready,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_all,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              map_we,
    output logic [ARCH_W-1:0] map_arch,
    output logic [PHYS_W-1:0] map_phys,
    output logic              free_we,
    output logic [PHYS_W-1:0] free_phys,
    output logic              sb_set_we,
    output logic [PHYS_W-1:0] sb_set_phys,
    output logic              sb_clr_we,
    output logic [PHYS_W-1:0] sb_clr_phys,
    output logic              busy,
    output logic              full,
    output logic [CNT_W-1:0]  occupancy,
    output logic [EV_W-1:0]   commits_done,
    output logic [EV_W-1:0]   undos_done
);
    localparam logic [PHYS_W:0] SPECIAL_BASE = (PHYS_W + 1)'(REGULAR_REGS);

    logic              push, pop_young, pop_old, empty, walking, st_full;
    logic [SEQ_W-1:0]  yng_seq, old_seq;
    logic [ARCH_W-1:0] yng_arch;
    logic [PHYS_W-1:0] yng_new, yng_prev, old_prev;

    assign alloc_ready = !st_full && !walking;
    assign push        = alloc_valid && alloc_ready;

    rul_store #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_seq(alloc_seq), .push_arch(alloc_arch),
        .push_new(alloc_new), .push_prev(alloc_prev),
        .pop_young(pop_young), .pop_old(pop_old),
        .count(occupancy), .empty(empty), .is_full(st_full),
        .yng_seq(yng_seq), .yng_arch(yng_arch), .yng_new(yng_new), .yng_prev(yng_prev),
        .old_seq(old_seq), .old_prev(old_prev)
    );

    rul_walker #(.SEQ_W(SEQ_W)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .flush_all(flush_all), .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_seq(commit_seq), .empty(empty), .yng_seq(yng_seq), .old_seq(old_seq),
        .pop_young(pop_young), .pop_old(pop_old), .walking(walking)
    );

    rul_event_ctr #(.W(EV_W)) u_retired (
        .clk(clk), .rst_n(rst_n), .inc(pop_old), .value(commits_done)
    );

    rul_event_ctr #(.W(EV_W)) u_undone (
        .clk(clk), .rst_n(rst_n), .inc(pop_young), .value(undos_done)
    );

    // Steer the popped record onto the map, free list and scoreboard ports.
    always_comb begin
        map_we      = pop_young;
        map_arch    = yng_arch;
        map_phys    = yng_prev;
        free_we     = pop_young || pop_old;
        free_phys   = pop_young ? yng_new : old_prev;
        sb_set_we   = pop_young && ({1'b0, yng_new} >= SPECIAL_BASE);
        sb_set_phys = yng_new;
        sb_clr_we   = push;
        sb_clr_phys = alloc_new;
    end

    assign busy = walking;
    assign full = st_full;

    // R3
    restore_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> free_we && busy);
    // R4
    ready_only_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_set_we |-> map_we);
    // R6
    walk_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(flush_all || squash_valid || commit_seq != '0));
    // R1
    no_alloc_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && alloc_valid |=> occupancy <= $past(occupancy));
endmodule

// File: tb/rename_undo_log_bench.sv
module rename_undo_log_bench;
    localparam int DEPTH = 8;
    localparam int SEQ_W = 16;
    localparam int ARCH_W = 5;
    localparam int PHYS_W = 7;
    localparam int REGULAR = 96;
    localparam int EV_W = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct { int seq; int arch; int nw; int pv; } rec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic av = 1'b0, sv = 1'b0, fl = 1'b0;
    logic [SEQ_W-1:0] a_seq = '0, s_seq = '0, c_seq = '0;
    logic [ARCH_W-1:0] a_arch = '0;
    logic [PHYS_W-1:0] a_new = '0, a_prev = '0;

    logic alloc_ready, map_we, free_we, sb_set_we, sb_clr_we, busy, full;
    logic [ARCH_W-1:0] map_arch;
    logic [PHYS_W-1:0] map_phys, free_phys, sb_set_phys, sb_clr_phys;
    logic [CNT_W-1:0] occupancy;
    logic [EV_W-1:0] commits_done, undos_done;

    int checks = 0, fails = 0;
    rec_t q[$];
    int mode = 0, tgt = 0, n_commit = 0, n_undo = 0;

    always #5 clk = ~clk;

    rename_undo_log #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W),
        .REGULAR_REGS(REGULAR), .EV_W(EV_W)
    ) u_rename_undo_log (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(av), .alloc_seq(a_seq), .alloc_arch(a_arch),
        .alloc_new(a_new), .alloc_prev(a_prev), .alloc_ready(alloc_ready),
        .squash_valid(sv), .squash_seq(s_seq), .flush_all(fl), .commit_seq(c_seq),
        .map_we(map_we), .map_arch(map_arch), .map_phys(map_phys),
        .free_we(free_we), .free_phys(free_phys),
        .sb_set_we(sb_set_we), .sb_set_phys(sb_set_phys),
        .sb_clr_we(sb_clr_we), .sb_clr_phys(sb_clr_phys),
        .busy(busy), .full(full), .occupancy(occupancy),
        .commits_done(commits_done), .undos_done(undos_done)
    );

    task automatic chk(string req, string sig, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
        end
    endtask

    task automatic idle_in();
        av = 1'b0; sv = 1'b0; fl = 1'b0; c_seq = '0;
    endtask

    // Compare this cycle against the model, then advance the model at the edge.
    task automatic step();
        bit e_busy, e_full, e_ready, acc, pn, po, e_set;
        int nm, nt;
        bit l_fl, l_sv;
        int l_s, l_c;
        rec_t y, o;
        #1;
        e_busy = (mode != 0);
        e_full = (q.size() == DEPTH);
        e_ready = !e_full && !e_busy;
        acc = av && e_ready;
        pn = 1'b0; po = 1'b0;
        if (q.size() > 0) begin y = q[$]; o = q[0]; end
        if (mode == 1) pn = (q.size() > 0) && (y.seq > tgt);
        else if (mode == 2) po = (q.size() > 0) && (o.seq <= tgt);
        else if (mode == 3) pn = (q.size() > 0);
        chk("R3", "busy", int'(busy), int'(e_busy));
        chk("R2", "full", int'(full), int'(e_full));
        chk("R2", "alloc_ready", int'(alloc_ready), int'(e_ready));
        chk("R1", "occupancy", int'(occupancy), q.size());
        chk("R1", "sb_clr_we", int'(sb_clr_we), int'(acc));
        if (acc) chk("R1", "sb_clr_phys", int'(sb_clr_phys), int'(a_new));
        chk("R3", "map_we", int'(map_we), int'(pn));
        if (pn) begin
            chk("R3", "map_arch", int'(map_arch), y.arch);
            chk("R3", "map_phys", int'(map_phys), y.pv);
        end
        chk("R5", "free_we", int'(free_we), int'(pn || po));
        if (pn) chk("R3", "free_phys", int'(free_phys), y.nw);
        if (po) chk("R5", "free_phys", int'(free_phys), o.pv);
        e_set = pn && (y.nw >= REGULAR);
        chk("R4", "sb_set_we", int'(sb_set_we), int'(e_set));
        if (e_set) chk("R4", "sb_set_phys", int'(sb_set_phys), y.nw);
        chk("R9", "commits_done", int'(commits_done), n_commit % 65536);
        chk("R9", "undos_done", int'(undos_done), n_undo % 65536);
        l_fl = fl; l_sv = sv; l_s = int'(s_seq); l_c = int'(c_seq);
        @(posedge clk);
        if (acc) q.push_back('{int'(a_seq), int'(a_arch), int'(a_new), int'(a_prev)});
        if (pn) begin void'(q.pop_back()); n_undo++; end
        if (po) begin void'(q.pop_front()); n_commit++; end
        nm = mode; nt = tgt;
        if ((mode == 1 || mode == 3) && !pn) nm = 0;
        if (mode == 2 && !po) nm = 0;
        if (mode != 3) begin
            if (l_fl) nm = 3;
            else if (l_sv) begin
                nt = (mode == 1 && tgt < l_s) ? tgt : l_s;
                nm = 1;
            end else if (mode == 0 && l_c != 0) begin
                nm = 2; nt = l_c;
            end
        end
        mode = nm; tgt = nt;
        @(negedge clk);
    endtask

    task automatic do_alloc(int s, int ar, int nw, int pv);
        idle_in(); av = 1'b1; a_seq = SEQ_W'(s); a_arch = ARCH_W'(ar);
        a_new = PHYS_W'(nw); a_prev = PHYS_W'(pv);
        step(); idle_in();
    endtask

    task automatic do_squash(int s);
        idle_in(); sv = 1'b1; s_seq = SEQ_W'(s); step(); idle_in();
    endtask

    task automatic do_commit(int d);
        idle_in(); c_seq = SEQ_W'(d); step(); idle_in();
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && mode != 0; i++) step();
        step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int nseq;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        #1;
        chk("R10", "occupancy", int'(occupancy), 0);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "alloc_ready", int'(alloc_ready), 1);
        chk("R10", "strobes", int'({map_we, free_we, sb_set_we}), 0);
        chk("R10", "commits_done", int'(commits_done), 0);
        chk("R10", "undos_done", int'(undos_done), 0);
        @(negedge clk);

        // R1: five records, one with a special new register
        do_alloc(10, 1, 40, 20);
        do_alloc(11, 2, 41, 21);
        do_alloc(12, 3, 42, 22);
        do_alloc(13, 4, 100, 23);
        do_alloc(14, 5, 45, 24);
        // R3, R4: squash removes 14 and 13
        do_squash(12); drain();
        chk("R3", "occupancy after squash", int'(occupancy), 3);
        // R5: retire 10 and 11, then a number older than the oldest
        do_commit(11); drain();
        chk("R5", "occupancy after retire", int'(occupancy), 1);
        do_commit(5); drain();
        chk("R5", "no-op retire", int'(commits_done), 2);
        // R6: commit with a squash in the same cycle is dropped
        idle_in(); sv = 1'b1; s_seq = 100; c_seq = 20; step(); idle_in(); drain();
        chk("R6", "commits_done", int'(commits_done), 2);
        // R6: commit during a squash walk is dropped; R1 alloc during walk refused
        do_alloc(15, 6, 50, 30);
        do_alloc(16, 7, 51, 31);
        do_alloc(17, 8, 120, 32);
        do_squash(15);
        do_commit(20);
        do_alloc(18, 9, 52, 33);
        drain();
        chk("R6", "occupancy", int'(occupancy), 2);
        // R8: squash preempts a retire walk
        do_commit(16); do_squash(12); drain();
        chk("R8", "occupancy", int'(occupancy), 0);
        chk("R8", "undos_done", int'(undos_done), 5);
        // R8: second squash lowers the target
        for (int i = 20; i < 26; i++) do_alloc(i, i % 32, 60 + i, i);
        do_squash(23); do_squash(21); drain();
        chk("R8", "occupancy merged", int'(occupancy), 2);
        // R2: fill to full and offer one more
        for (int i = 30; i < 36; i++) do_alloc(i, i % 32, i + 70, i);
        chk("R2", "full", int'(full), 1);
        do_alloc(36, 1, 1, 1);
        chk("R2", "occupancy held", int'(occupancy), DEPTH);
        // R7: flush takes over a squash walk
        do_squash(33); idle_in(); fl = 1'b1; step(); idle_in(); drain();
        chk("R7", "occupancy", int'(occupancy), 0);
        // R7: flush beats a same-cycle squash
        do_alloc(40, 3, 110, 9);
        do_alloc(41, 4, 111, 10);
        idle_in(); fl = 1'b1; sv = 1'b1; s_seq = 40; step(); idle_in(); drain();
        chk("R7", "occupancy", int'(occupancy), 0);

        // Mixed traffic against the model
        nseq = 100;
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            idle_in();
            if (r < 45) begin
                av = 1'b1; a_seq = SEQ_W'(nseq); nseq++;
                a_arch = ARCH_W'($urandom_range(0, 31));
                a_new = PHYS_W'($urandom_range(0, 127));
                a_prev = PHYS_W'($urandom_range(0, 127));
            end else if (r < 52) begin
                sv = 1'b1; s_seq = SEQ_W'(nseq - $urandom_range(0, 6));
            end else if (r < 66) begin
                c_seq = SEQ_W'(nseq - $urandom_range(1, 8));
            end else if (r < 68) begin
                fl = 1'b1;
            end
            step();
        end
        idle_in(); drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule